// File: doc/BRIEF.md
# I2C EEPROM Target Protocol Engine

This block is the bus-facing engine of a small serial EEPROM of up to 256 bytes. A fast system clock samples the two I2C lines through synchronizers. The engine recognises START and STOP, answers one fixed 7-bit device address, and takes an 8-bit word address. It then runs byte writes, page writes, current-address reads, random reads with a repeated START, and sequential reads. It pulls SDA low only through an open-drain enable output.

The engine keeps no storage of its own. Reads come from a combinational memory port driven by the engine's word-address counter. Each accepted write byte is handed to an external write-commit unit as a load strobe carrying address and data. A STOP that closes a valid write session raises a one-cycle commit pulse. The commit unit reports two conditions back. While it reports busy, the engine acknowledges nothing. While it reports protection, data bytes are refused.

Top module: `i2c_eeprom_target`

## Requirements
- R1: SDA falling while SCL is high (START) aborts any transfer and restarts byte reception at the device-address byte. SDA rising while SCL is high (STOP) returns the engine to idle. After either event the open-drain enable is low, and nothing is acknowledged until the next START.
- R2: A device byte whose upper seven bits equal 7'b1010000 is acknowledged. Its bit 0 is the direction: 1 means read and 0 means write. Any other device byte leaves SDA released in the ninth clock.
- R3: In a write, the byte after the device byte loads the word address and is acknowledged. Each following data byte is acknowledged and raises `buf_we_o` for one cycle with its address and data. A STOP after at least one accepted data byte pulses `commit_o` for one cycle.
- R4: During a write, the address increments only in its low four bits. After offset 15 of a 16-byte page it returns to offset 0 of the same page, and the upper bits are kept.
- R5: When `wr_prot_i` is high at the acknowledge decision of a data byte, that byte is not acknowledged, no load strobe occurs, and the following STOP gives no commit pulse.
- R6: While `wr_busy_i` is high, the device byte is not acknowledged, whether it is a read or a write.
- R7: A read that is not preceded by a word-address byte returns the byte at the internal address. That address is the last loaded address, moved on by every byte transferred since.
- R8: A repeated START after an acknowledged word-address byte, followed by a read device byte, returns the byte at the loaded address.
- R9: After each read byte, a controller ACK (SDA low in the ninth clock) starts the next byte from the incremented address. The 8-bit counter goes from 255 to 0. A controller NACK ends the read, and SDA stays released.
- R10: Incoming bits are taken when SCL rises. The enable changes only while the sampled SCL is low, or when a START or STOP is seen, so read data is stable for the whole high phase of SCL.
- R11: A STOP after an address-only write gives no commit pulse. A START that cuts a write session short also prevents any commit at the later STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level (wired-AND bus) |
| sda_oe | output | 1 | 1 pulls SDA low |
| wr_busy_i | input | 1 | Commit unit is writing the array |
| wr_prot_i | input | 1 | Writes are refused |
| mem_raddr_o | output | 8 | Read address to the array |
| mem_rdata_i | input | 8 | Array data at mem_raddr_o, combinational |
| buf_we_o | output | 1 | One-cycle load strobe for an accepted data byte |
| buf_addr_o | output | 8 | Address of the loaded byte |
| buf_data_o | output | 8 | Data of the loaded byte |
| commit_o | output | 1 | One-cycle pulse to start the internal write |

## Verification
The hardest case is a write session cut short. A data byte has already been accepted and loaded, and then a START arrives partway through the next byte, so the later STOP must not commit. The bench stops after four bits of a data byte and issues a repeated START. It then runs a read and a STOP. It checks that the commit count is unchanged and that the read continues from the address after the accepted byte. The 255-to-0 rollover and the in-page wrap are reached by loading addresses next to those boundaries.

// File: rtl/i2c_eeprom_pkg.sv
package i2c_eeprom_pkg;
  localparam int WADDR_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK_OUT,
    ST_TX,
    ST_ACK_IN
  } eng_st_t;

  typedef enum logic [1:0] {
    RX_DEV,
    RX_WADDR,
    RX_WDATA
  } rx_kind_t;

  function automatic logic dev_match(input logic [7:0] b, input logic [6:0] id);
    return b[7:1] == id;
  endfunction

  function automatic logic [WADDR_W-1:0] read_next(input logic [WADDR_W-1:0] a);
    return a + 1'b1;
  endfunction

  function automatic logic [WADDR_W-1:0] page_next(input logic [WADDR_W-1:0] a,
                                                   input logic [WADDR_W-1:0] mask);
    logic [WADDR_W-1:0] inc;
    inc = a + 1'b1;
    return (a & ~mask) | (inc & mask);
  endfunction
endpackage

// File: rtl/i2c_line_sampler.sv
module i2c_line_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  logic [1:0] scl_sync, sda_sync;
  logic       scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync <= 2'b11;
      sda_sync <= 2'b11;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[0], scl_i};
      sda_sync <= {sda_sync[0], sda_i};
      scl_q    <= scl_sync[1];
      sda_q    <= sda_sync[1];
    end
  end

  assign scl_lvl   = scl_sync[1];
  assign sda_lvl   = sda_sync[1];
  assign scl_rise  = scl_lvl & ~scl_q;
  assign scl_fall  = ~scl_lvl & scl_q;
  assign bus_start = scl_lvl & scl_q & sda_q & ~sda_lvl;
  assign bus_stop  = scl_lvl & scl_q & ~sda_q & sda_lvl;
endmodule

// File: rtl/i2c_addr_ctr.sv
module i2c_addr_ctr
  import i2c_eeprom_pkg::*;
#(
  parameter int PAGE_BYTES = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [WADDR_W-1:0] load_val,
  input  logic               inc_rd,
  input  logic               inc_wr,
  output logic [WADDR_W-1:0] addr
);
  localparam logic [WADDR_W-1:0] PAGE_MASK = WADDR_W'(PAGE_BYTES - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      addr <= '0;
    else if (load)   addr <= load_val;
    else if (inc_wr) addr <= page_next(addr, PAGE_MASK);
    else if (inc_rd) addr <= read_next(addr);
  end
endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target
  import i2c_eeprom_pkg::*;
#(
  parameter logic [6:0] DEV_ID     = 7'b1010000,
  parameter int         PAGE_BYTES = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic       wr_busy_i,
  input  logic       wr_prot_i,
  output logic [7:0] mem_raddr_o,
  input  logic [7:0] mem_rdata_i,
  output logic       buf_we_o,
  output logic [7:0] buf_addr_o,
  output logic [7:0] buf_data_o,
  output logic       commit_o
);
  logic scl_lvl, sda_lvl, scl_rise, scl_fall, ev_start, ev_stop;

  i2c_line_sampler u_smp (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .bus_start(ev_start), .bus_stop(ev_stop)
  );

  eng_st_t    st;
  rx_kind_t   kind;
  logic [3:0] cnt;
  logic [7:0] rx_sr, tx_sr;
  logic       rd_mode, m_ack, wr_valid;
  logic [7:0] cur_addr;

  // named internal events
  logic ev_decide, ev_dev_decide, dev_ok, ev_addr_load, ev_data_take, ev_rd_step;
  assign ev_decide     = scl_fall && st == ST_RX && cnt == 4'd8;
  assign ev_dev_decide = ev_decide && kind == RX_DEV;
  assign dev_ok        = dev_match(rx_sr, DEV_ID) && !wr_busy_i;
  assign ev_addr_load  = ev_decide && kind == RX_WADDR;
  assign ev_data_take  = ev_decide && kind == RX_WDATA && !wr_prot_i;
  assign ev_rd_step    = scl_fall && st == ST_TX && cnt == 4'd8;

  i2c_addr_ctr #(.PAGE_BYTES(PAGE_BYTES)) u_ctr (
    .clk(clk), .rst_n(rst_n),
    .load(ev_addr_load && !ev_start && !ev_stop), .load_val(rx_sr),
    .inc_rd(ev_rd_step && !ev_start && !ev_stop),
    .inc_wr(ev_data_take && !ev_start && !ev_stop),
    .addr(cur_addr)
  );

  assign mem_raddr_o = cur_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;  kind <= RX_DEV;  cnt <= '0;
      rx_sr <= '0;  tx_sr <= '0;  sda_oe <= 1'b0;
      rd_mode <= 1'b0;  m_ack <= 1'b0;  wr_valid <= 1'b0;
      commit_o <= 1'b0;  buf_we_o <= 1'b0;
      buf_addr_o <= '0;  buf_data_o <= '0;
    end else begin
      commit_o <= 1'b0;
      buf_we_o <= 1'b0;
      if (ev_start) begin
        st <= ST_RX;  kind <= RX_DEV;  cnt <= '0;
        sda_oe <= 1'b0;  wr_valid <= 1'b0;
      end else if (ev_stop) begin
        commit_o <= wr_valid;
        st <= ST_IDLE;  sda_oe <= 1'b0;  wr_valid <= 1'b0;
      end else begin
        case (st)
          ST_RX: begin
            if (scl_rise) begin
              rx_sr <= {rx_sr[6:0], sda_lvl};
              cnt   <= cnt + 4'd1;
            end else if (ev_decide) begin
              case (kind)
                RX_DEV: begin
                  if (dev_ok) begin
                    sda_oe <= 1'b1;  st <= ST_ACK_OUT;  rd_mode <= rx_sr[0];
                  end else st <= ST_IDLE;
                end
                RX_WADDR: begin
                  sda_oe <= 1'b1;  st <= ST_ACK_OUT;
                end
                default: begin
                  if (!wr_prot_i) begin
                    sda_oe <= 1'b1;  st <= ST_ACK_OUT;
                    buf_we_o <= 1'b1;  buf_addr_o <= cur_addr;  buf_data_o <= rx_sr;
                    wr_valid <= 1'b1;
                  end else begin
                    st <= ST_IDLE;  wr_valid <= 1'b0;
                  end
                end
              endcase
            end
          end
          ST_ACK_OUT: begin
            if (scl_rise) cnt <= cnt + 4'd1;
            else if (scl_fall && cnt == 4'd9) begin
              cnt <= '0;
              if (kind == RX_DEV && rd_mode) begin
                tx_sr  <= mem_rdata_i;
                sda_oe <= ~mem_rdata_i[7];
                st     <= ST_TX;
              end else begin
                sda_oe <= 1'b0;
                st     <= ST_RX;
                kind   <= (kind == RX_DEV) ? RX_WADDR : RX_WDATA;
              end
            end
          end
          ST_TX: begin
            if (scl_rise) cnt <= cnt + 4'd1;
            else if (ev_rd_step) begin
              sda_oe <= 1'b0;  st <= ST_ACK_IN;
            end else if (scl_fall) begin
              tx_sr  <= {tx_sr[6:0], 1'b0};
              sda_oe <= ~tx_sr[6];
            end
          end
          ST_ACK_IN: begin
            if (scl_rise) begin
              m_ack <= ~sda_lvl;  cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd9) begin
              cnt <= '0;
              if (m_ack) begin
                tx_sr <= mem_rdata_i;  sda_oe <= ~mem_rdata_i[7];  st <= ST_TX;
              end else st <= ST_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_eeprom_target_chk.sv
module i2c_eeprom_target_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_lvl,
  input logic ev_start,
  input logic ev_stop,
  input logic ev_dev_decide,
  input logic wr_busy_i,
  input logic wr_prot_i,
  input logic sda_oe,
  input logic buf_we_o,
  input logic commit_o
);
  AST_START_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> !sda_oe);                                               // R1
  AST_BUSY_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_dev_decide && wr_busy_i) |=> !sda_oe);                            // R6
  AST_COMMIT_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |-> $past(ev_stop));                                        // R3
  AST_PROT_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we_o |-> !$past(wr_prot_i));                                     // R5
  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> (!$past(scl_lvl) || $past(ev_start) || $past(ev_stop))); // R10
endmodule

bind i2c_eeprom_target i2c_eeprom_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .ev_start(ev_start),
  .ev_stop(ev_stop), .ev_dev_decide(ev_dev_decide), .wr_busy_i(wr_busy_i),
  .wr_prot_i(wr_prot_i), .sda_oe(sda_oe), .buf_we_o(buf_we_o), .commit_o(commit_o)
);

// File: tb/i2c_eeprom_target_bench.sv
`timescale 1ns/1ps
module i2c_eeprom_target_bench;
  localparam int Q = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_ctl = 1'b1;
  logic wr_busy = 1'b0, wr_prot = 1'b0;
  logic sda_oe, buf_we, commit;
  logic [7:0] raddr, rdata, baddr, bdata;
  wire  sda_bus = sda_ctl & ~sda_oe;

  always #10 clk = ~clk;

  logic [7:0] mem [256];
  logic [7:0] exp_mem [256];
  logic [7:0] pend_d [256];
  logic       pend_v [256];
  assign rdata = mem[raddr];

  i2c_eeprom_target u_i2c_eeprom_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .wr_busy_i(wr_busy), .wr_prot_i(wr_prot), .mem_raddr_o(raddr),
    .mem_rdata_i(rdata), .buf_we_o(buf_we), .buf_addr_o(baddr),
    .buf_data_o(bdata), .commit_o(commit)
  );

  int n_chk = 0, n_fail = 0, n_commit = 0;
  bit finished = 0;
  logic [15:0] wq [$];

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // monitor: loads and commits
  always @(posedge clk) begin
    if (buf_we) begin
      if (wq.size() == 0) chk(0, "R5 unexpected load", {baddr, bdata}, 0);
      else begin
        logic [15:0] e;
        e = wq.pop_front();
        chk({baddr, bdata} == e, "R3/R4 load addr,data", {baddr, bdata}, e);
      end
      pend_d[baddr] = bdata;
      pend_v[baddr] = 1'b1;
    end
    if (commit) begin
      n_commit++;
      for (int i = 0; i < 256; i++)
        if (pend_v[i]) begin mem[i] = pend_d[i]; pend_v[i] = 1'b0; end
    end
  end

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask

  task automatic clk_bit(input logic v, output logic s, output bit stable);
    logic s2;
    tick(Q); sda_ctl = v; tick(Q); scl = 1'b1;
    tick(Q); s = sda_bus; tick(Q); s2 = sda_bus; scl = 1'b0;
    stable = (s == s2);
  endtask

  task automatic bus_start;
    sda_ctl = 1'b1; tick(Q); scl = 1'b1; tick(Q); sda_ctl = 1'b0; tick(Q); scl = 1'b0;
  endtask

  task automatic bus_stop;
    tick(Q); sda_ctl = 1'b0; tick(Q); scl = 1'b1; tick(Q); sda_ctl = 1'b1; tick(4*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic nack);
    logic s; bit st;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s, st);
    clk_bit(1'b1, nack, st);
  endtask

  task automatic recv_byte(input bit ack, output logic [7:0] d, output bit stable);
    logic s; bit st;
    stable = 1;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s, st);
      d[i] = s;
      stable &= st;
    end
    clk_bit(ack ? 1'b0 : 1'b1, s, st);
  endtask

  task automatic wr_byte(input logic [7:0] b, input bit exp_ack, input string req);
    logic nack;
    send_byte(b, nack);
    chk(nack == !exp_ack, req, nack, !exp_ack);
  endtask

  task automatic rd_check(input bit ack, input logic [7:0] expv, input string req);
    logic [7:0] d; bit st;
    recv_byte(ack, d, st);
    chk(d == expv, req, d, expv);
    chk(st, "R10 data stable while SCL high", st, 1);
  endtask

  task automatic commit_check(input int expv, input string req);
    tick(4);
    chk(n_commit == expv, req, n_commit, expv);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i) ^ 8'h3C; exp_mem[i] = 8'(i) ^ 8'h3C; pend_v[i] = 1'b0; pend_d[i] = '0;
    end
    tick(5);
    chk(sda_oe == 1'b0 && commit == 1'b0, "R1 reset state", {sda_oe, commit}, 0);
    rst_n = 1'b1;
    tick(5);

    // R2 wrong device addresses
    bus_start(); wr_byte(8'hA2, 0, "R2 wrong low address bits NACK"); bus_stop();
    bus_start(); wr_byte(8'hB0, 0, "R2 wrong high nibble NACK"); bus_stop();

    // R3 byte write
    bus_start(); wr_byte(8'hA0, 1, "R2 own address ACK");
    wr_byte(8'h10, 1, "R3 word address ACK");
    wq.push_back({8'h10, 8'h5A}); exp_mem[8'h10] = 8'h5A;
    wr_byte(8'h5A, 1, "R3 data ACK");
    bus_stop(); commit_check(1, "R3 commit at STOP");

    // R8 random read, then R7 current read
    bus_start(); wr_byte(8'hA0, 1, "R8 device ACK"); wr_byte(8'h10, 1, "R8 address ACK");
    bus_start(); wr_byte(8'hA1, 1, "R8 read device ACK");
    rd_check(0, exp_mem[8'h10], "R8 random read data"); bus_stop();
    bus_start(); wr_byte(8'hA1, 1, "R7 read device ACK");
    rd_check(0, exp_mem[8'h11], "R7 current-address read"); bus_stop();

    // R4 page write wrap
    bus_start(); wr_byte(8'hA0, 1, "R4 device ACK"); wr_byte(8'h2E, 1, "R4 address ACK");
    wq.push_back({8'h2E, 8'hC1}); exp_mem[8'h2E] = 8'hC1; wr_byte(8'hC1, 1, "R4 data0 ACK");
    wq.push_back({8'h2F, 8'hC2}); exp_mem[8'h2F] = 8'hC2; wr_byte(8'hC2, 1, "R4 data1 ACK");
    wq.push_back({8'h20, 8'hC3}); exp_mem[8'h20] = 8'hC3; wr_byte(8'hC3, 1, "R4 data2 ACK");
    bus_stop(); commit_check(2, "R4 page commit");
    bus_start(); wr_byte(8'hA0, 1, "R9 device ACK"); wr_byte(8'h2E, 1, "R9 address ACK");
    bus_start(); wr_byte(8'hA1, 1, "R9 read ACK");
    rd_check(1, exp_mem[8'h2E], "R9 seq byte 0"); rd_check(0, exp_mem[8'h2F], "R9 seq byte 1");
    bus_stop();
    bus_start(); wr_byte(8'hA0, 1, "R4 device ACK"); wr_byte(8'h20, 1, "R4 address ACK");
    bus_start(); wr_byte(8'hA1, 1, "R4 read ACK");
    rd_check(0, exp_mem[8'h20], "R4 wrapped byte in page"); bus_stop();

    // R9 rollover 255 -> 0
    bus_start(); wr_byte(8'hA0, 1, "R9 device ACK"); wr_byte(8'hFE, 1, "R9 address ACK");
    bus_start(); wr_byte(8'hA1, 1, "R9 read ACK");
    rd_check(1, exp_mem[8'hFE], "R9 byte FE"); rd_check(1, exp_mem[8'hFF], "R9 byte FF");
    rd_check(0, exp_mem[8'h00], "R9 rollover to 00"); bus_stop();
    tick(20); chk(sda_oe == 1'b0, "R9 SDA released after NACK", sda_oe, 0);

    // R5 protection
    wr_prot = 1'b1;
    bus_start(); wr_byte(8'hA0, 1, "R5 device ACK"); wr_byte(8'h60, 1, "R5 address ACK");
    wr_byte(8'h99, 0, "R5 data NACK while protected");
    bus_stop(); commit_check(2, "R5 no commit");
    bus_start(); wr_byte(8'hA0, 1, "R5 device ACK"); wr_byte(8'h60, 1, "R5 address ACK");
    bus_start(); wr_byte(8'hA1, 1, "R5 read ACK");
    rd_check(0, exp_mem[8'h60], "R5 memory unchanged"); bus_stop();
    wr_prot = 1'b0;

    // R6 busy
    wr_busy = 1'b1;
    bus_start(); wr_byte(8'hA0, 0, "R6 write device NACK while busy"); bus_stop();
    bus_start(); wr_byte(8'hA1, 0, "R6 read device NACK while busy"); bus_stop();
    wr_busy = 1'b0;

    // R11 address-only write, then R7 current read from loaded address
    bus_start(); wr_byte(8'hA0, 1, "R11 device ACK"); wr_byte(8'h55, 1, "R11 address ACK");
    bus_stop(); commit_check(2, "R11 no commit on address-only write");
    bus_start(); wr_byte(8'hA1, 1, "R7 read ACK");
    rd_check(0, exp_mem[8'h55], "R7 read at loaded address"); bus_stop();

    // R11/R1 START aborts a write session
    bus_start(); wr_byte(8'hA0, 1, "R11 device ACK"); wr_byte(8'h40, 1, "R11 address ACK");
    wq.push_back({8'h40, 8'h77}); wr_byte(8'h77, 1, "R11 data ACK");
    begin
      logic s; bit st;
      for (int i = 0; i < 4; i++) clk_bit(1'b0, s, st);
    end
    bus_start(); wr_byte(8'hA1, 1, "R1 device ACK after restart");
    rd_check(0, exp_mem[8'h41], "R1 read after abort");
    bus_stop(); commit_check(2, "R11 no commit after START abort");
    chk(wq.size() == 0, "R3 all expected loads seen", wq.size(), 0);

    tick(20);
    summary();
  end
endmodule